// File: doc/BRIEF.md
# Microframe Idle Low-Power Controller

This block watches a high-speed serial bus for quiet periods inside every 125 µs microframe and raises a low-power request once the bus has stayed quiet for longer than one sixteenth of a microframe. Once raised, the request does not drop when traffic returns. It drops only at the next start-of-microframe pulse. A downstream power controller can therefore park receivers and transmitters for the rest of the frame and wake them in time for the next frame marker.

A bus-activity strobe and a start-of-microframe detect pulse come from the analog and packet front end. A role select picks which of two enable bits governs the feature: one bit for the host role and one for the device role. A pin-strap input forces the feature on whatever those bits say. A free-running frame watchdog restarts on every start-of-microframe pulse. If frame markers stop arriving, the watchdog ends any request on its own, so the block can never stay in low power indefinitely. The idle threshold, the frame length and the watchdog tolerance are parameters counted in clock cycles. At 480 MHz the defaults are 3750, 60000 and 600 cycles.

Top module: `mfidle_lp_ctrl`

## Requirements
- R1: After reset, `lp_req` is 0 and `lp_armed` is 1, so the feature is on by default.
- R2: When the feature is enabled, `lp_req` rises at the clock edge that samples the (IDLE_CYC+1)-th consecutive cycle with both `bus_active` and `sof_pulse` low.
- R3: A clock edge that samples `sof_pulse` high leaves `lp_req` low after that edge and restarts the idle count. The first idle cycle after the pulse counts as one.
- R4: Once high, `lp_req` stays high through any amount of `bus_active` until a start-of-microframe, a watchdog expiry or a disable.
- R5: While `lp_req` is low, an edge that samples `bus_active` high restarts the idle count. A further IDLE_CYC+1 idle cycles are then needed before a request.
- R6: While `strap_mode` is 1, `host_lp_en` and `dev_lp_en` have no effect and the feature behaves as enabled.
- R7: With `strap_mode` at 0, the governing enable bit is `host_lp_en` when `role_host` is 1 and `dev_lp_en` when `role_host` is 0. The other role's bit has no effect. If the governing bit is 0, `lp_req` is low after the next edge and no request forms.
- R8: If no `sof_pulse` is sampled for FRAME_CYC+FRAME_TOL edges in a row, counted from reset, the last pulse or the last expiry, then the last of those edges forces `lp_req` low and restarts both the idle count and the watchdog.
- R9: `lp_armed` shows, one edge later, whether the feature is effectively enabled: 1 means enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_active | input | 1 | High in any cycle the bus carries traffic |
| sof_pulse | input | 1 | One-cycle pulse at each start of microframe |
| role_host | input | 1 | 1 selects the host role, 0 the device role |
| host_lp_en | input | 1 | Feature enable for the host role |
| dev_lp_en | input | 1 | Feature enable for the device role |
| strap_mode | input | 1 | 1 forces the feature on and ignores the enable bits |
| lp_req | output | 1 | Low-power request, held until the next frame start |
| lp_armed | output | 1 | Registered effective-enable status |

## Verification
The bench places idle runs exactly one cycle short of the threshold and exactly on it. An off-by-one counter would raise the request a cycle early or late. A burst of activity just before the threshold catches a counter that does not restart. Activity after the request is raised catches a design that wakes on traffic instead of on the frame marker. Role, strap and enable changes are made while a request is pending, and runs are checked with only the non-governing bit cleared, to expose a wrong enable selection or a slow disable. A long run with no frame markers checks that the watchdog ends the request on the exact edge and that counting starts fresh afterwards.

// File: rtl/mfidle_pkg.sv
package mfidle_pkg;

  // Why the request was dropped in a given cycle; NONE means no clear.
  typedef enum logic [1:0] {
    LP_CLR_NONE    = 2'd0,
    LP_CLR_SOF     = 2'd1,
    LP_CLR_EXPIRE  = 2'd2,
    LP_CLR_DISABLE = 2'd3
  } lp_clr_e;

  // Effective enable: strap wins, otherwise the bit of the active role.
  function automatic logic pick_enable(input logic strap, input logic host_role,
                                       input logic host_en, input logic dev_en);
    return strap | (host_role ? host_en : dev_en);
  endfunction

  // Total cycles the watchdog waits for a frame marker.
  function automatic int unsigned wdog_limit(input int unsigned frame_cyc,
                                             input int unsigned tol_cyc);
    return frame_cyc + tol_cyc;
  endfunction

  // Bits needed to hold values 0..max_val.
  function automatic int unsigned bits_for(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

  // Idle run crosses the threshold when the saturated count equals it
  // and the present cycle is idle too.
  function automatic logic crosses(input int unsigned count, input int unsigned thr,
                                   input logic quiet);
    return quiet && (count == thr);
  endfunction

endpackage

// File: rtl/mfidle_en_sel.sv
module mfidle_en_sel
  import mfidle_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strap_mode,
  input  logic role_host,
  input  logic host_lp_en,
  input  logic dev_lp_en,
  output logic en_now,
  output logic armed_q
);

  assign en_now = pick_enable(strap_mode, role_host, host_lp_en, dev_lp_en);

  // Status copy, on after reset so the feature reads as enabled by default.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b1;
    else        armed_q <= en_now;
  end

endmodule

// File: rtl/mfidle_idle_cnt.sv
module mfidle_idle_cnt
  import mfidle_pkg::*;
#(
  parameter int unsigned IDLE_CYC = 3750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic activity,
  input  logic hold,
  output logic idle_hit
);

  localparam int unsigned CW = bits_for(IDLE_CYC);
  localparam logic [CW-1:0] THR = CW'(IDLE_CYC);

  logic [CW-1:0] cnt_q;
  logic          quiet;

  assign quiet    = !activity && !restart && !hold;
  assign idle_hit = crosses(int'(cnt_q), IDLE_CYC, quiet);

  // Count consecutive quiet cycles, saturating at the threshold.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!quiet)       cnt_q <= '0;
    else if (cnt_q != THR) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/mfidle_frame_wdog.sv
module mfidle_frame_wdog
  import mfidle_pkg::*;
#(
  parameter int unsigned FRAME_CYC = 60000,
  parameter int unsigned FRAME_TOL = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sof_pulse,
  output logic expire
);

  localparam int unsigned LIMIT = wdog_limit(FRAME_CYC, FRAME_TOL);
  localparam int unsigned CW    = bits_for(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign expire = !sof_pulse && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (sof_pulse || expire) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/mfidle_lp_ctrl.sv
module mfidle_lp_ctrl
  import mfidle_pkg::*;
#(
  parameter int unsigned IDLE_CYC  = 3750,
  parameter int unsigned FRAME_CYC = 60000,
  parameter int unsigned FRAME_TOL = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_active,
  input  logic sof_pulse,
  input  logic role_host,
  input  logic host_lp_en,
  input  logic dev_lp_en,
  input  logic strap_mode,
  output logic lp_req,
  output logic lp_armed
);

  logic    en_now;
  logic    idle_hit;
  logic    frame_expire;
  logic    lp_req_q;
  lp_clr_e clr_why;

  mfidle_en_sel u_en (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_mode (strap_mode),
    .role_host  (role_host),
    .host_lp_en (host_lp_en),
    .dev_lp_en  (dev_lp_en),
    .en_now     (en_now),
    .armed_q    (lp_armed)
  );

  mfidle_frame_wdog #(
    .FRAME_CYC (FRAME_CYC),
    .FRAME_TOL (FRAME_TOL)
  ) u_wdog (
    .clk       (clk),
    .rst_n     (rst_n),
    .sof_pulse (sof_pulse),
    .expire    (frame_expire)
  );

  // Priority of clear reasons: frame marker, then watchdog, then disable.
  always_comb begin
    if (sof_pulse)         clr_why = LP_CLR_SOF;
    else if (frame_expire) clr_why = LP_CLR_EXPIRE;
    else if (!en_now)      clr_why = LP_CLR_DISABLE;
    else                   clr_why = LP_CLR_NONE;
  end

  mfidle_idle_cnt #(
    .IDLE_CYC (IDLE_CYC)
  ) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (clr_why != LP_CLR_NONE),
    .activity (bus_active),
    .hold     (lp_req_q),
    .idle_hit (idle_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       lp_req_q <= 1'b0;
    else if (clr_why != LP_CLR_NONE)  lp_req_q <= 1'b0;
    else if (idle_hit)                lp_req_q <= 1'b1;
  end

  assign lp_req = lp_req_q;

endmodule

// File: rtl/mfidle_lp_chk.sv
module mfidle_lp_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_active,
  input logic sof_pulse,
  input logic strap_mode,
  input logic en_now,
  input logic idle_hit,
  input logic frame_expire,
  input logic lp_req,
  input logic lp_armed
);

  AST_SOF_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    sof_pulse |=> !lp_req); // R3

  AST_IDLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_hit && en_now && !sof_pulse && !frame_expire) |=> lp_req); // R2

  AST_RISE_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lp_req) |-> $past(idle_hit)); // R2

  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_req && en_now && !sof_pulse && !frame_expire) |=> lp_req); // R4

  AST_ACT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && !lp_req) |=> !lp_req); // R5

  AST_STRAP_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    strap_mode |=> lp_armed); // R6

  AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_now |=> !lp_req); // R7

  AST_EXPIRE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_expire |=> !lp_req); // R8

endmodule

bind mfidle_lp_ctrl mfidle_lp_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_active   (bus_active),
  .sof_pulse    (sof_pulse),
  .strap_mode   (strap_mode),
  .en_now       (en_now),
  .idle_hit     (idle_hit),
  .frame_expire (frame_expire),
  .lp_req       (lp_req),
  .lp_armed     (lp_armed)
);

// File: tb/sim_mfidle_lp_ctrl.sv
module sim_mfidle_lp_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int IDLE  = 20;
  localparam int FRAME = 200;
  localparam int TOL   = 10;
  localparam int LIM   = FRAME + TOL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_active = 1'b0, sof_pulse = 1'b0;
  logic role_host = 1'b1, host_lp_en = 1'b1, dev_lp_en = 1'b1, strap_mode = 1'b0;
  logic lp_req, lp_armed;

  // Shadow configuration applied at the next driven cycle.
  logic c_role = 1'b1, c_he = 1'b1, c_de = 1'b1, c_strap = 1'b0;

  typedef struct {
    bit    ck_lp;
    bit    e_lp;
    bit    ck_arm;
    bit    e_arm;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mfidle_lp_ctrl #(
    .IDLE_CYC  (IDLE),
    .FRAME_CYC (FRAME),
    .FRAME_TOL (TOL)
  ) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_active (bus_active),
    .sof_pulse  (sof_pulse),
    .role_host  (role_host),
    .host_lp_en (host_lp_en),
    .dev_lp_en  (dev_lp_en),
    .strap_mode (strap_mode),
    .lp_req     (lp_req),
    .lp_armed   (lp_armed)
  );

  // Driver: one cycle of stimulus plus the expected outputs after its edge.
  task automatic step(input logic act, input logic sof, input bit ck, input bit elp,
                      input bit cka, input bit earm, input string tag);
    exp_t it;
    @(negedge clk);
    bus_active = act;
    sof_pulse  = sof;
    role_host  = c_role;
    host_lp_en = c_he;
    dev_lp_en  = c_de;
    strap_mode = c_strap;
    it.ck_lp = ck; it.e_lp = elp; it.ck_arm = cka; it.e_arm = earm; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic sof(input string tag);
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic idle(input int n, input bit elp, input string tag);
    for (int k = 0; k < n; k++) step(1'b0, 1'b0, 1'b1, elp, 1'b0, 1'b0, tag);
  endtask

  // IDLE quiet cycles with no request, then the request on the next one.
  task automatic run_to_req(input string tag);
    idle(IDLE, 1'b0, tag);
    idle(1, 1'b1, tag);
  endtask

  // Monitor: pops one expectation per edge, compares after the edge settles.
  initial begin
    exp_t it;
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && sb_q.size() > 0) begin
        it = sb_q.pop_front();
        if (it.ck_lp) begin
          n_vec++;
          if (lp_req !== it.e_lp) begin
            n_bad++;
            $display("FAIL %s: lp_req=%0b expected %0b at %0t", it.tag, lp_req, it.e_lp, $time);
          end
        end
        if (it.ck_arm) begin
          n_vec++;
          if (lp_armed !== it.e_arm) begin
            n_bad++;
            $display("FAIL %s: lp_armed=%0b expected %0b at %0t", it.tag, lp_armed, it.e_arm, $time);
          end
        end
      end
    end
  end

  initial begin
    exp_t it;
    repeat (3) @(negedge clk);
    // R1: reset values seen right after release
    n_vec += 2;
    if (lp_req !== 1'b0) begin n_bad++; $display("FAIL R1: lp_req=%0b expected 0", lp_req); end
    if (lp_armed !== 1'b1) begin n_bad++; $display("FAIL R1: lp_armed=%0b expected 1", lp_armed); end
    rst_n = 1'b1;
    it.ck_lp = 1; it.e_lp = 0; it.ck_arm = 1; it.e_arm = 1; it.tag = "R1";
    sb_q.push_back(it);

    // R2, R4, R3: threshold, hold through traffic, wake only at frame start
    sof("R3");
    run_to_req("R2");
    idle(5, 1'b1, "R4");
    for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R4");
    sof("R3");
    run_to_req("R3");
    sof("R3");

    // R5: activity one cycle short of the threshold restarts the count
    idle(IDLE, 1'b0, "R5");
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
    run_to_req("R5");
    sof("R5");

    // R7, R9: clearing the host bit drops a pending request on the next edge
    run_to_req("R7");
    c_he = 1'b0;
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R7");
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
    idle(IDLE + 5, 1'b0, "R7");
    // R7: the device bit cleared has no effect in host role
    c_he = 1'b1; c_de = 1'b0;
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R9");
    run_to_req("R7");
    // R7: device role follows the device bit
    c_role = 1'b0;
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R7");
    idle(IDLE + 3, 1'b0, "R7");
    c_de = 1'b1;
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R9");
    run_to_req("R7");

    // R6: strap forces the feature on with both bits clear
    c_role = 1'b1; c_he = 1'b0; c_de = 1'b0; c_strap = 1'b1;
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R6");
    run_to_req("R6");
    c_strap = 1'b0;
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R6");
    c_he = 1'b1; c_de = 1'b1;
    sof("R6");

    // R8: watchdog ends the request after LIM edges with no frame marker
    for (int j = 1; j <= LIM; j++) begin
      if (j == LIM) step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
      else          step(1'b0, 1'b0, 1'b1, (j > IDLE), 1'b0, 1'b0, "R8");
    end
    run_to_req("R8");
    sof("R8");

    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule